// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block holds the memory-window registers of a PCI-to-PCI style bridge and decodes addresses against them. There are two windows. One is non-prefetchable and lies in the low 4 GB. The other is prefetchable and is reached through a 64-bit address: its upper 32 bits must equal a separate upper-base register. Each window has a 12-bit base and a 12-bit limit, matched against address bits 31:20, so every window is aligned to 1 MB.

Configuration software writes the registers through a simple port. That port takes a dword index, four byte enables and 32 bits of data, and it reads back combinationally at the same index.

The decode port takes an address, a direction flag and a valid strobe. One cycle later the block reports the hit flags and its verdict. A downstream access is forwarded when it hits a window and the memory-space enable is set. An upstream access is accepted when it misses both windows and the bus-master enable is set.

Top module: `bridge_mem_window_dec`

## Requirements
- R1: After reset, index 8 reads 00000000h, index 9 reads 00010001h and index 10 reads 00000000h.
- R2: In the base/limit dwords at index 8 (non-prefetchable) and index 9 (prefetchable), the limit is held in bits 31:20 and the base in bits 15:4. At index 8, bits 19:16 and 3:0 always read zero.
- R3: At index 9, bits 19:16 and 3:0 always read 1h, and writes to those bits are ignored.
- R4: A write updates only the byte lanes whose enable bit is set. Enable bit n covers data bits 8n+7:8n.
- R5: The upper-base register at index 10 is writable across all 32 bits.
- R6: An address whose bits 63:32 are zero hits the non-prefetchable window when bits 31:20 are at least the base and strictly below the limit.
- R7: An address hits the prefetchable window only when bits 63:32 equal the upper-base register and bits 31:20 are at least the prefetchable base and strictly below its limit.
- R8: A downstream access (direction 0) is forwarded only when it hits a window and mem_en is set. A downstream access is never accepted.
- R9: An upstream access (direction 1) is accepted only when it misses both windows and master_en is set. An upstream access is never forwarded.
- R10: The decode outputs are registered. They reflect the request presented one clock earlier, and they are all zero when no request was valid.
- R11: A window whose base equals its limit is empty and matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 6 | Dword index for register read and write |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data at reg_idx (combinational) |
| mem_en | input | 1 | Memory-space enable |
| master_en | input | 1 | Bus-master enable |
| dec_valid | input | 1 | Decode request valid |
| dec_upstream | input | 1 | 1 = upstream access, 0 = downstream access |
| dec_addr | input | 64 | Address to decode |
| out_valid | output | 1 | Registered decode result valid |
| out_np_hit | output | 1 | Address hit the non-prefetchable window |
| out_pf_hit | output | 1 | Address hit the prefetchable window |
| out_forward | output | 1 | Forward the downstream access |
| out_accept | output | 1 | Accept the upstream access |

## Verification
The hardest cases to reach are the edges of each window and the prefetchable window's dependence on the upper address half.

To reach the window edges, the bench programs known bases and limits through partial byte-enable writes. It then presents addresses exactly at the base, one below it, at the last byte under the limit, and at the limit itself.

For the upper-half dependence, the bench reuses the same low 32 bits with several upper halves. It also sets base equal to limit to show that an empty window matches nothing.

Each of these is repeated in both directions with the two enables toggled.

// File: rtl/bridge_mem_window_dec.sv
module bridge_mem_window_dec #(
  parameter int IDX_W  = 6,
  parameter int NP_IDX = 8,
  parameter int PF_IDX = 9,
  parameter int UP_IDX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             reg_wr,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             mem_en,
  input  logic             master_en,
  input  logic             dec_valid,
  input  logic             dec_upstream,
  input  logic [63:0]      dec_addr,
  output logic             out_valid,
  output logic             out_np_hit,
  output logic             out_pf_hit,
  output logic             out_forward,
  output logic             out_accept
);
  localparam logic [3:0] IND64 = 4'h1;

  logic [11:0] np_base, np_lim, pf_base, pf_lim;
  logic [31:0] pf_up;

  wire wr_np = reg_wr && reg_idx == IDX_W'(NP_IDX);
  wire wr_pf = reg_wr && reg_idx == IDX_W'(PF_IDX);
  wire wr_up = reg_wr && reg_idx == IDX_W'(UP_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      np_base <= '0;
      np_lim  <= '0;
      pf_base <= '0;
      pf_lim  <= '0;
      pf_up   <= '0;
    end else begin
      if (wr_np) begin
        if (reg_be[0]) np_base[3:0]  <= reg_wdata[7:4];
        if (reg_be[1]) np_base[11:4] <= reg_wdata[15:8];
        if (reg_be[2]) np_lim[3:0]   <= reg_wdata[23:20];
        if (reg_be[3]) np_lim[11:4]  <= reg_wdata[31:24];
      end
      if (wr_pf) begin
        if (reg_be[0]) pf_base[3:0]  <= reg_wdata[7:4];
        if (reg_be[1]) pf_base[11:4] <= reg_wdata[15:8];
        if (reg_be[2]) pf_lim[3:0]   <= reg_wdata[23:20];
        if (reg_be[3]) pf_lim[11:4]  <= reg_wdata[31:24];
      end
      if (wr_up)
        for (int b = 0; b < 4; b++)
          if (reg_be[b]) pf_up[8*b +: 8] <= reg_wdata[8*b +: 8];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_idx == IDX_W'(NP_IDX))      reg_rdata = {np_lim, 4'h0, np_base, 4'h0};
    else if (reg_idx == IDX_W'(PF_IDX)) reg_rdata = {pf_lim, IND64, pf_base, IND64};
    else if (reg_idx == IDX_W'(UP_IDX)) reg_rdata = pf_up;
  end

  wire [11:0] a_mb  = dec_addr[31:20];
  wire        np_in = dec_addr[63:32] == 32'h0 && a_mb >= np_base && a_mb < np_lim;
  wire        pf_in = dec_addr[63:32] == pf_up && a_mb >= pf_base && a_mb < pf_lim;
  wire        any_in = np_in || pf_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_np_hit  <= 1'b0;
      out_pf_hit  <= 1'b0;
      out_forward <= 1'b0;
      out_accept  <= 1'b0;
    end else begin
      out_valid   <= dec_valid;
      out_np_hit  <= dec_valid && np_in;
      out_pf_hit  <= dec_valid && pf_in;
      out_forward <= dec_valid && !dec_upstream && any_in && mem_en;
      out_accept  <= dec_valid && dec_upstream && !any_in && master_en;
    end
  end

  AST_IND_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx == IDX_W'(PF_IDX) |-> reg_rdata[19:16] == IND64 && reg_rdata[3:0] == IND64); // R3
  AST_NP_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx == IDX_W'(NP_IDX) |-> reg_rdata[19:16] == 4'h0 && reg_rdata[3:0] == 4'h0); // R2
  AST_FWD_NEEDS_MSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_forward |-> $past(mem_en) && !$past(dec_upstream) && (out_np_hit || out_pf_hit)); // R8
  AST_ACC_NEEDS_BME: assert property (@(posedge clk) disable iff (!rst_n)
    out_accept |-> $past(master_en) && $past(dec_upstream) && !out_np_hit && !out_pf_hit); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_np_hit && !out_pf_hit && !out_forward && !out_accept); // R10
  AST_EMPTY_NP: assert property (@(posedge clk) disable iff (!rst_n)
    (np_base == np_lim) && dec_valid |=> !out_np_hit); // R11
  AST_PF_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_addr[63:32] != pf_up |=> !out_pf_hit); // R7
endmodule

// File: tb/test_bridge_mem_window_dec.sv
module test_bridge_mem_window_dec;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  reg_idx = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_en = 0, master_en = 0, dec_valid = 0, dec_upstream = 0;
  logic [63:0] dec_addr = 0;
  logic        out_valid, out_np_hit, out_pf_hit, out_forward, out_accept;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  bridge_mem_window_dec i_bridge_mem_window_dec (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    reg_idx = idx[5:0]; reg_be = be; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(string req, int idx, logic [31:0] exp);
    @(negedge clk);
    reg_idx = idx[5:0];
    #1 chk(req, reg_rdata, exp);
  endtask

  // expected vector: {valid, np, pf, fwd, acc}
  task automatic dec(string req, logic [63:0] a, logic up, logic mse, logic bme, logic [4:0] exp);
    @(negedge clk);
    dec_valid = 1; dec_addr = a; dec_upstream = up; mem_en = mse; master_en = bme;
    @(negedge clk);
    dec_valid = 0;
    chk(req, {out_valid, out_np_hit, out_pf_hit, out_forward, out_accept}, exp);
  endtask

  task automatic t_reset;
    rd("R1", 8, 32'h0);
    rd("R1", 9, 32'h0001_0001);
    rd("R1", 10, 32'h0);
    chk("R10", {out_valid, out_np_hit, out_pf_hit, out_forward, out_accept}, 0);
  endtask

  task automatic t_regs;
    wr(8, 4'hF, 32'hFFFF_FFFF);
    rd("R2", 8, 32'hFFF0_FFF0);
    wr(9, 4'hF, 32'h0000_0000);
    rd("R3", 9, 32'h0001_0001);
    wr(8, 4'b0011, 32'h0000_1230);
    rd("R4", 8, 32'hFFF0_1230);
    wr(8, 4'b1100, 32'h2000_0000);
    rd("R4", 8, 32'h2000_1230);
    wr(10, 4'hF, 32'hDEAD_BEEF);
    rd("R5", 10, 32'hDEAD_BEEF);
    wr(10, 4'b0100, 32'h0012_0000);
    rd("R4", 10, 32'hDE12_BEEF);
  endtask

  task automatic t_np_window;
    wr(8, 4'hF, 32'h2000_1000);
    dec("R6", 64'h1000_0000, 0, 1, 0, 5'b11010);
    dec("R6", 64'h0FFF_FFFF, 0, 1, 0, 5'b10000);
    dec("R6", 64'h1FFF_FFFF, 0, 1, 0, 5'b11010);
    dec("R6", 64'h2000_0000, 0, 1, 0, 5'b10000);
    dec("R6", 64'h1_1000_0000, 0, 1, 0, 5'b10000);
  endtask

  task automatic t_pf_window;
    wr(10, 4'hF, 32'h0000_0001);
    wr(9, 4'hF, 32'h9000_8000);
    rd("R2", 9, 32'h9001_8001);
    dec("R7", 64'h1_8000_0000, 0, 1, 0, 5'b10110);
    dec("R7", 64'h1_8FFF_FFFF, 0, 1, 0, 5'b10110);
    dec("R7", 64'h1_9000_0000, 0, 1, 0, 5'b10000);
    dec("R7", 64'h0_8000_0000, 0, 1, 0, 5'b10000);
    dec("R7", 64'h2_8000_0000, 0, 1, 0, 5'b10000);
  endtask

  task automatic t_enables;
    dec("R8", 64'h1000_0000, 0, 0, 1, 5'b11000);
    dec("R8", 64'h3000_0000, 0, 1, 1, 5'b10000);
    dec("R9", 64'h3000_0000, 1, 1, 1, 5'b10001);
    dec("R9", 64'h3000_0000, 1, 1, 0, 5'b10000);
    dec("R9", 64'h1000_0000, 1, 1, 1, 5'b11000);
    dec("R9", 64'h1_8000_0000, 1, 1, 1, 5'b10100);
    @(negedge clk);
    chk("R10", {out_valid, out_np_hit, out_pf_hit, out_forward, out_accept}, 0);
  endtask

  task automatic t_empty;
    wr(8, 4'hF, 32'h3000_3000);
    dec("R11", 64'h3000_0000, 0, 1, 0, 5'b10000);
    dec("R11", 64'h3000_0000, 1, 1, 1, 5'b10001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_np_window;
    t_pf_window;
    t_enables;
    t_empty;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule